// File: doc/BRIEF.md
# Cumulative Tone Window Detector

This block turns a stream of per-packet verdicts into a steady, debounced indication that a metering tone is on the line. An upstream stage measures the signal period. For every packet of 32 tone cycles it pulses a strobe and reports whether that packet was good. The block keeps the verdicts of the most recent packets in a sliding window. The window spans 48 ms. In 16 kHz operation it holds 24 packets, and in 12 kHz operation it holds 18 packets.

The output is active low. It falls once the good packets in the window add up to 40 ms, which is 20 packets at 16 kHz or 15 at 12 kHz. It rises again only when the bad packets in the window reach the same amount. Between those two points it keeps its level. As a result, short bursts of tone and short fades do not move the output. The window is reassessed on every strobe. Changing the system select input clears the window to all-bad and releases the output.

Top module: `cumtone_window`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, tone_n is 1 and every packet in the window counts as bad.
- R2: On the clock edge that samples a strobe, tone_n becomes 0 if the good packets among the most recent window packets, including the new one, reach the threshold. The window is 24 packets and the threshold is 20 when sys_12k is 0.
- R3: On the clock edge that samples a strobe, tone_n becomes 1 if the bad packets in the window reach the threshold.
- R4: When neither count reaches the threshold after a strobe, tone_n keeps its previous value.
- R5: When sys_12k is 1, the window is 18 packets and the threshold is 15.
- R6: Starting from an all-bad window, an unbroken run of good packets drives tone_n low on exactly the 20th strobe (16 kHz) or the 15th strobe (12 kHz), and not earlier.
- R7: In cycles without a strobe, pkt_good has no effect. The window and tone_n stay unchanged.
- R8: A clock edge at which sys_12k differs from the value sampled at the previous edge clears the window to all-bad and sets tone_n to 1. A strobe in that same cycle is discarded.
- R9: The window slides. Each strobe drops the oldest packet, so only the last window-length packets count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_12k | input | 1 | System select: 1 = 12 kHz (18-packet window), 0 = 16 kHz (24-packet window) |
| pkt_stb | input | 1 | One-cycle pulse marking the end of a packet |
| pkt_good | input | 1 | Packet verdict, sampled with pkt_stb: 1 = good |
| tone_n | output | 1 | Active-low tone present, registered |

## Verification
The bench first goes after the exact strobe on which the output flips. This is the 20th or 15th consecutive good packet on the way down, and the matching bad count on the way up. An off-by-one threshold or a comparison written as greater-than rather than at-least would move that edge by one packet. Runs of 19 bad packets after a full window probe the hold band. A design that released on a simple majority would go high there. Long mixed streams in both modes catch a design that drops the wrong bit when the window slides, because its count would drift from the true window contents. Mode switches, including one that coincides with a strobe, catch stale history carried across modes and strobes that should have been discarded.

// File: rtl/cumtone_window.sv
module cumtone_window #(
  parameter int WIN_HI = 24,
  parameter int THR_HI = 20,
  parameter int WIN_LO = 18,
  parameter int THR_LO = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_12k,
  input  logic pkt_stb,
  input  logic pkt_good,
  output logic tone_n
);
  localparam int WMAX = (WIN_HI > WIN_LO) ? WIN_HI : WIN_LO;
  localparam int CW   = $clog2(WMAX + 1);

  logic [WMAX-1:0] hist;
  logic [CW-1:0]   good_cnt;
  logic [CW-1:0]   cnt_nx;
  logic [CW-1:0]   win;
  logic [CW-1:0]   thr;
  logic            sys_q;
  logic            drop;

  assign win    = sys_q ? CW'(WIN_LO) : CW'(WIN_HI);
  assign thr    = sys_q ? CW'(THR_LO) : CW'(THR_HI);
  assign drop   = sys_q ? hist[WIN_LO-1] : hist[WIN_HI-1];
  assign cnt_nx = good_cnt + CW'(pkt_good) - CW'(drop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist     <= '0;
      good_cnt <= '0;
      tone_n   <= 1'b1;
      sys_q    <= sys_12k;
    end else if (sys_12k != sys_q) begin
      sys_q    <= sys_12k;
      hist     <= '0;
      good_cnt <= '0;
      tone_n   <= 1'b1;
    end else if (pkt_stb) begin
      hist     <= {hist[WMAX-2:0], pkt_good};
      good_cnt <= cnt_nx;
      if (cnt_nx >= thr)
        tone_n <= 1'b0;
      else if ((win - cnt_nx) >= thr)
        tone_n <= 1'b1;
    end
  end
endmodule

module cumtone_window_chk #(
  parameter int WIN_HI = 24,
  parameter int THR_HI = 20,
  parameter int WIN_LO = 18,
  parameter int THR_LO = 15,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sys_12k,
  input logic          sys_q,
  input logic          pkt_stb,
  input logic [CW-1:0] good_cnt,
  input logic          tone_n
);
  int unsigned w, t;
  assign w = sys_q ? WIN_LO : WIN_HI;
  assign t = sys_q ? THR_LO : THR_HI;

  a_r1_reset_high: assert property (@(posedge clk) !rst_n |=> tone_n);

  a_r7_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_stb && sys_12k == sys_q) |=> $stable(tone_n) && $stable(good_cnt));

  a_r8_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_12k != sys_q) |=> tone_n && good_cnt == '0);

  a_r2_fall_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tone_n) |-> int'(good_cnt) >= t);

  a_r3_rise_needs_bad: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_n) |-> (w - int'(good_cnt)) >= t);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(good_cnt) <= w);
endmodule

bind cumtone_window cumtone_window_chk #(
  .WIN_HI(WIN_HI), .THR_HI(THR_HI), .WIN_LO(WIN_LO), .THR_LO(THR_LO), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_12k(sys_12k), .sys_q(sys_q),
  .pkt_stb(pkt_stb), .good_cnt(good_cnt), .tone_n(tone_n)
);

// File: tb/cumtone_window_bench.sv
module cumtone_window_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_12k = 1'b0;
  logic pkt_stb = 1'b0;
  logic pkt_good = 1'b0;
  logic tone_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cumtone_window u_cumtone_window (
    .clk(clk), .rst_n(rst_n), .sys_12k(sys_12k),
    .pkt_stb(pkt_stb), .pkt_good(pkt_good), .tone_n(tone_n)
  );

  bit q[$];
  bit m_sys;
  bit m_out;
  int m_win, m_thr;

  function automatic void mclear();
    q.delete();
    m_win = m_sys ? 18 : 24;
    m_thr = m_sys ? 15 : 20;
    for (int i = 0; i < m_win; i++) q.push_back(1'b0);
    m_out = 1'b1;
  endfunction

  function automatic void model_edge();
    int n;
    if (sys_12k != m_sys) begin
      m_sys = sys_12k;
      mclear();
    end else if (pkt_stb) begin
      q.push_front(pkt_good);
      void'(q.pop_back());
      n = 0;
      foreach (q[i]) n += q[i];
      if (n >= m_thr) m_out = 1'b0;
      else if (m_win - n >= m_thr) m_out = 1'b1;
    end
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tone_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic g, input string tag);
    pkt_stb = s;
    pkt_good = g;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    pkt_stb = 1'b0;
    check(tag, tone_n, m_out);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", tone_n, 1'b1);
    rst_n = 1'b1;
    m_sys = sys_12k;
    mclear();
    @(negedge clk);
    check("R1 after reset", tone_n, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R6 / R2: 16 kHz, 19 goods keep high, the 20th drives low
    for (int i = 0; i < 19; i++) step(1'b1, 1'b1, "R6 before threshold");
    check("R6 still high after 19", tone_n, 1'b1);
    step(1'b1, 1'b1, "R2 R6 20th good");
    check("R2 low on 20th", tone_n, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R2 fill");

    // R7: pkt_good toggles without strobe
    for (int i = 0; i < 10; i++) step(1'b0, i[0], "R7 no strobe");
    check("R7 held low", tone_n, 1'b0);

    // R4 / R3: 19 bads hold low, 20th releases
    for (int i = 0; i < 19; i++) step(1'b1, 1'b0, "R4 hold band");
    check("R4 low after 19 bad", tone_n, 1'b0);
    step(1'b1, 1'b0, "R3 20th bad");
    check("R3 high after 20 bad", tone_n, 1'b1);

    // R9: sliding bursts with gaps
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 7; i++) step(1'b1, 1'b1, "R9 burst");
      step(1'b1, 1'b0, "R9 fade");
      step(1'b0, 1'b1, "R7 idle");
    end

    // R8: mode change with a strobe in the same cycle
    sys_12k = 1'b1;
    step(1'b1, 1'b1, "R8 switch to 12k");
    check("R8 forced high", tone_n, 1'b1);

    // R5 / R6: 12 kHz threshold 15
    for (int i = 0; i < 14; i++) step(1'b1, 1'b1, "R5 before threshold");
    check("R5 high after 14", tone_n, 1'b1);
    step(1'b1, 1'b1, "R5 R6 15th good");
    check("R5 low on 15th", tone_n, 1'b0);
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, "R4 12k hold");
    step(1'b1, 1'b0, "R3 12k release");
    check("R3 12k high", tone_n, 1'b1);

    // R9: mixed streams in both modes
    for (int seg = 0; seg < 12; seg++) begin
      int p = 40 + (seg % 6) * 10;
      if (seg == 6) sys_12k = 1'b0;
      for (int i = 0; i < 60; i++)
        step(($urandom % 4) != 0, ($urandom % 100) < p, "R9 mixed stream");
    end

    // R8: switch back while low
    for (int i = 0; i < 24; i++) step(1'b1, 1'b1, "R2 refill");
    sys_12k = 1'b1;
    step(1'b0, 1'b0, "R8 switch while low");
    check("R8 released", tone_n, 1'b1);

    do_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule